// File: doc/BRIEF.md
# Two-Operand ALU Execute Unit

This unit carries out one 16-bit ALU instruction per clock on a 16-bit datapath backed by eight general-purpose registers, which are part of the block. Each cycle the word on `instr` is decoded and its operands are read from the register file. The result and the four status flags are produced within the cycle. Both commit on the rising edge that closes the cycle, so a dependent instruction can follow in the very next cycle.

Three instruction shapes share one opcode field. A register-immediate form works on one register and a zero-extended 8-bit constant. A three-register form writes one register from two others. A flag-only form compares or tests two registers and leaves the register file untouched. In the register form, the two-bit field in bits 4:3 turns the add and subtract slots into their carry-consuming variants. For the other six opcodes, the same field turns them into flag tests. The slot of the or opcode becomes an additive compare, and the slot of or-not becomes a subtractive compare.

Top module: `alu2_exec_unit`

## Requirements
- R1: While `rst` is high on a clock edge, all eight registers and all four flags become zero.
- R2: A word with bit 15 = 1 and bit 11 = 1 is a register-immediate operation. The register named by bits 10:8 is both the first operand and the destination. The second operand is bits 7:0 zero-extended to 16 bits, and the write is always performed.
- R3: A word with bit 15 = 1, bit 11 = 0 and bits 4:3 = 00 writes to the register named by bits 10:8. Its first operand comes from bits 7:5 and its second from bits 2:0.
- R4: Bits 14:12 choose the operation: 000 A+B, 001 A−B, 010 A^B, 011 ~(A^B), 100 A|B, 101 A|~B, 110 A&B, 111 A&~B.
- R5: In register form with bits 4:3 = 01, opcode 000 writes A+B+C and opcode 001 writes A+~B+C, where C is the current carry flag. In both cases the result goes to the register named by bits 10:8.
- R6: In register form with bits 4:3 = 01 and any opcode from 010 to 111, no register is written and only the flags change. Opcodes 010, 011, 110 and 111 keep their logic meaning. Opcode 100 computes A+B, and opcode 101 computes A−B.
- R7: The flag vector is {Z,N,C,V}, with Z at bit 3 and V at bit 0. Z is set when the 16-bit result is zero, and N is result bit 15. For add, C is the carry out; for subtract, C is not-borrow. V is signed overflow. Logic operations clear both C and V. `flags_next` shows the flags the current word will commit.
- R8: The register write and the flag update take effect on the same rising edge, so `flags` then equals the `flags_next` of the cycle before. An instruction in the next cycle reads the updated register.
- R9: Nothing is written and the flags hold (`flags_next` equals `flags`) in three cases: `instr_valid` is low, bit 15 is 0, or the word is in register form with bits 4:3 = 1x.
- R10: A test reports true by setting Z. Equivalence, complement and both compares set Z when their condition is met. The bit test clears Z when the operands share any set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The word on `instr` is executed this cycle |
| instr | input | 16 | Instruction word |
| wr_en | output | 1 | A register is written at the end of this cycle |
| wr_addr | output | 3 | Destination register |
| wr_data | output | 16 | Result to be written |
| flags_next | output | 4 | Flags to be committed, {Z,N,C,V} |
| flags | output | 4 | Committed status flags, {Z,N,C,V} |

## Verification
In one cycle, the carry flag committed by the previous instruction can feed the adder of a carry-consuming add or subtract, while a register written in that same previous edge is read as an operand. The bench provokes this with long streams of back-to-back random ALU words. These streams are interleaved with register loads built from dependent chains of immediate operations and self-adds, so nearly every instruction depends on its predecessor's result and flags. Every output is compared against an arithmetic model kept in the bench, which is updated at each edge. This means a stale operand or a stale carry shows up as a result or flag mismatch in the very cycle it is used.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

    localparam int DATA_W = 16;
    localparam int REG_N  = 8;
    localparam int ADDR_W = $clog2(REG_N);
    localparam int IMM_W  = 8;
    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_XOR  = 3'd2,
        OP_XNOR = 3'd3,
        OP_OR   = 3'd4,
        OP_ORN  = 3'd5,
        OP_AND  = 3'd6,
        OP_ANDN = 3'd7
    } alu_op_e;

    // bit 3 = Z, bit 0 = V
    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              act;
        logic              wr;
        alu_op_e           op;
        logic              use_cin;
        logic              imm_src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src_a;
        logic [ADDR_W-1:0] src_b;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic logic [DATA_W-1:0] logic_fn(
        input alu_op_e           op,
        input logic [DATA_W-1:0] a,
        input logic [DATA_W-1:0] b
    );
        logic [DATA_W-1:0] r;
        case (op)
            OP_XOR:  r = a ^ b;
            OP_XNOR: r = ~(a ^ b);
            OP_OR:   r = a | b;
            OP_ORN:  r = a | ~b;
            OP_AND:  r = a & b;
            default: r = a & ~b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu2_regfile.sv
module alu2_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Reads see the array after the previous edge, so a write is
    // visible to the instruction in the following cycle.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/alu2_decode.sv
module alu2_decode
    import alu2_pkg::*;
(
    input  logic              valid,
    input  logic [DATA_W-1:0] instr,
    output dec_t              dec
);

    alu_op_e raw_op;
    logic    is_imm;
    logic    alt_form;
    logic    flag_only;

    always_comb begin
        raw_op    = alu_op_e'(instr[14:12]);
        is_imm    = instr[11];
        alt_form  = !is_imm && instr[3];
        flag_only = alt_form && (instr[14:13] != 2'b00);

        dec.act     = valid && instr[15] && (is_imm || !instr[4]);
        dec.wr      = dec.act && !flag_only;
        dec.use_cin = alt_form && (instr[14:13] == 2'b00);
        dec.imm_src = is_imm;
        dec.imm     = instr[IMM_W-1:0];
        dec.dst     = instr[10:8];
        dec.src_a   = is_imm ? instr[10:8] : instr[7:5];
        dec.src_b   = instr[2:0];

        // compare slots reuse the adder
        dec.op = raw_op;
        if (alt_form && raw_op == OP_OR)  dec.op = OP_ADD;
        if (alt_form && raw_op == OP_ORN) dec.op = OP_SUB;
    end

endmodule

// File: rtl/alu2_datapath.sv
module alu2_datapath
    import alu2_pkg::*;
(
    input  alu_op_e           op,
    input  logic              use_cin,
    input  logic              imm_src,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb_reg,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output flags_t            fl
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] b_eff;
    logic              is_arith;
    logic              is_sub;
    logic              cin;
    logic [DATA_W:0]   sum;

    always_comb begin
        opb      = imm_src ? {{(DATA_W-IMM_W){1'b0}}, imm} : opb_reg;
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        is_sub   = (op == OP_SUB);
        b_eff    = is_sub ? ~opb : opb;
        cin      = use_cin ? c_in : is_sub;
        sum      = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

        if (is_arith) begin
            result = sum[MSB:0];
            fl.c   = sum[DATA_W];
            fl.v   = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
        end else begin
            result = logic_fn(op, opa, opb);
            fl.c   = 1'b0;
            fl.v   = 1'b0;
        end
        fl.z = (result == '0);
        fl.n = result[MSB];
    end

endmodule

// File: rtl/alu2_exec_unit.sv
module alu2_exec_unit
    import alu2_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     instr_valid,
    input  logic [DATA_W-1:0]        instr,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [DATA_W-1:0]        wr_data,
    output logic [FLAG_W-1:0]        flags_next,
    output logic [FLAG_W-1:0]        flags
);

    dec_t              dec;
    flags_t            flags_q;
    flags_t            flags_calc;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] result;

    alu2_decode u_dec (
        .valid (instr_valid),
        .instr (instr),
        .dec   (dec)
    );

    alu2_regfile #(.DATA_W(DATA_W), .DEPTH(REG_N)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (dec.wr),
        .waddr   (dec.dst),
        .wdata   (result),
        .raddr_a (dec.src_a),
        .raddr_b (dec.src_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    alu2_datapath u_dp (
        .op      (dec.op),
        .use_cin (dec.use_cin),
        .imm_src (dec.imm_src),
        .imm     (dec.imm),
        .opa     (rd_a),
        .opb_reg (rd_b),
        .c_in    (flags_q.c),
        .result  (result),
        .fl      (flags_calc)
    );

    always_ff @(posedge clk) begin
        if (rst)          flags_q <= '0;
        else if (dec.act) flags_q <= flags_calc;
    end

    assign wr_en      = dec.wr;
    assign wr_addr    = dec.dst;
    assign wr_data    = result;
    assign flags_next = dec.act ? flags_calc : flags_q;
    assign flags      = flags_q;

endmodule

// File: rtl/alu2_exec_unit_chk.sv
module alu2_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [7:0]  instr_hi,
    input logic [1:0]  form,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [3:0]  flags_next,
    input logic [3:0]  flags
);

    logic imm_word;
    logic test_word;
    assign imm_word  = instr_valid && instr_hi[7] && instr_hi[3];
    assign test_word = instr_valid && instr_hi[7] && !instr_hi[3]
                       && form == 2'b01 && instr_hi[6:5] != 2'b00;

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> flags == 4'h0);

    // R2
    imm_dest_chk: assert property (@(posedge clk) disable iff (rst)
        imm_word |-> wr_en && wr_addr == instr_hi[2:0]);

    // R6
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        test_word |-> !wr_en);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> flags_next[3] == (wr_data == 16'h0));

    // R8
    flags_commit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> flags == $past(flags_next));

    // R9
    no_idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !wr_en && flags_next == flags);

endmodule

bind alu2_exec_unit alu2_exec_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_hi    (instr[15:8]),
    .form        (instr[4:3]),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .flags_next  (flags_next),
    .flags       (flags)
);

// File: tb/tb_alu2_exec_unit.sv
`timescale 1ns/1ps
module tb_alu2_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  flags_next;
    logic [3:0]  flags;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [15:0] mreg [8];
    logic [3:0]  mflags;
    logic [31:0] seed = 32'h1234_5678;

    alu2_exec_unit dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:16];
    endfunction

    function automatic string cls(input logic [15:0] ins, input logic v);
        if (!v || !ins[15] || (!ins[11] && ins[4])) return "R9";
        if (ins[11]) return "R2";
        if (!ins[3]) return "R3";
        if (ins[14:13] == 2'b00) return "R5";
        return "R6";
    endfunction

    // Arithmetic reference model of the requirements
    task automatic model(input logic [15:0] ins, input logic v,
                         output logic ew, output logic [2:0] ea,
                         output logic [15:0] ed, output logic [3:0] ef);
        logic [2:0]  op;
        logic        imm, alt, c, ov;
        logic [15:0] a, b, r;
        int          u, s, cin, eff;
        ew = 1'b0; ea = ins[10:8]; ed = 16'h0; ef = mflags;
        if (!v || !ins[15]) return;
        imm = ins[11];
        if (!imm && ins[4]) return;
        op  = ins[14:12];
        alt = !imm && ins[3];
        a   = imm ? mreg[ins[10:8]] : mreg[ins[7:5]];
        b   = imm ? {8'h00, ins[7:0]} : mreg[ins[2:0]];
        eff = int'(op);
        if (alt && op == 3'd4) eff = 0;
        if (alt && op == 3'd5) eff = 1;
        c = 1'b0; ov = 1'b0;
        case (eff)
            0: begin
                cin = (alt && op == 3'd0) ? int'(mflags[1]) : 0;
                u = int'(a) + int'(b) + cin;
                s = int'($signed(a)) + int'($signed(b)) + cin;
                r = u[15:0]; c = (u > 65535); ov = (s > 32767) || (s < -32768);
            end
            1: begin
                cin = (alt && op == 3'd1) ? int'(mflags[1]) : 1;
                u = int'(a) - int'(b) - (1 - cin);
                s = int'($signed(a)) - int'($signed(b)) - (1 - cin);
                r = u[15:0]; c = (u >= 0); ov = (s > 32767) || (s < -32768);
            end
            2: r = a ^ b;
            3: r = ~(a ^ b);
            4: r = a | b;
            5: r = a | ~b;
            6: r = a & b;
            default: r = a & ~b;
        endcase
        ed = r;
        ef = {(r == 16'h0), r[15], c, ov};
        ew = !(alt && op[2:1] != 2'b00);
    endtask

    task automatic step(input logic [15:0] ins, input logic v, input string tag);
        logic ew; logic [2:0] ea; logic [15:0] ed; logic [3:0] ef;
        @(negedge clk);
        instr = ins; instr_valid = v;
        #2;
        model(ins, v, ew, ea, ed, ef);
        chk({tag, " wr_en"}, {15'h0, wr_en}, {15'h0, ew});
        if (ew) begin
            chk({tag, " wr_addr"}, {13'h0, wr_addr}, {13'h0, ea});
            chk({tag, " wr_data"}, wr_data, ed);
        end
        chk("R7 flags_next", {12'h0, flags_next}, {12'h0, ef});
        @(posedge clk);
        if (ew) mreg[ea] = ed;
        mflags = ef;
        #2;
        chk("R8 committed flags", {12'h0, flags}, {12'h0, mflags});
    endtask

    function automatic logic [15:0] enc_i(input int op, input int r, input logic [7:0] k);
        return {1'b1, 3'(op), 1'b1, 3'(r), k};
    endfunction

    function automatic logic [15:0] enc_r(input int op, input int y, input int a,
                                          input int fm, input int b);
        return {1'b1, 3'(op), 1'b0, 3'(y), 3'(a), 2'(fm), 3'(b)};
    endfunction

    task automatic load(input int r, input logic [15:0] val);
        step(enc_i(6, r, 8'h00), 1'b1, "R2");
        step(enc_i(4, r, val[15:8]), 1'b1, "R2");
        for (int i = 0; i < 8; i++) step(enc_r(0, r, r, 0, r), 1'b1, "R3");
        step(enc_i(4, r, val[7:0]), 1'b1, "R2");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = 16'h0;
        mflags = 4'h0;
        repeat (3) @(posedge clk);
        #2;
        // R1: flags cleared by reset
        chk("R1 flags after reset", {12'h0, flags}, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        // R1: every register reads zero (OR with 0 exposes it)
        for (int r = 0; r < 8; r++) step(enc_i(4, r, 8'h00), 1'b1, "R1 reg read");

        // R4: each opcode through the immediate form
        load(1, 16'hA5C3);
        for (int op = 0; op < 8; op++) step(enc_i(op, 1, 8'h3C), 1'b1, "R4");
        // R4: each opcode through the register form
        load(2, 16'h8001); load(3, 16'h7FFF);
        for (int op = 0; op < 8; op++) step(enc_r(op, 4, 2, 0, 3), 1'b1, "R4");

        // R5: carry chain, 0xFFFF + 1 carries, then 1+1+C = 3
        load(2, 16'hFFFF); load(3, 16'h0001);
        step(enc_r(0, 4, 2, 0, 3), 1'b1, "R5");
        chk("R5 carry out", {15'h0, flags[1]}, 16'h1);
        step(enc_r(0, 5, 3, 1, 3), 1'b1, "R5");
        step(enc_i(4, 5, 8'h00), 1'b1, "R5 read");
        chk("R5 addc result", wr_data, 16'h0003);
        step(enc_r(1, 6, 3, 1, 2), 1'b1, "R5");

        // R10: test polarity
        load(6, 16'h00F0); load(7, 16'h0F00);
        step(enc_r(6, 0, 6, 1, 7), 1'b1, "R10");
        chk("R10 TST disjoint Z", {15'h0, flags[3]}, 16'h1);
        step(enc_r(6, 0, 6, 1, 6), 1'b1, "R10");
        chk("R10 TST overlap Z", {15'h0, flags[3]}, 16'h0);
        step(enc_r(2, 0, 6, 1, 6), 1'b1, "R10");
        chk("R10 TEQ equal Z", {15'h0, flags[3]}, 16'h1);
        step(enc_r(5, 0, 6, 1, 7), 1'b1, "R10");
        chk("R10 CMP unequal Z", {15'h0, flags[3]}, 16'h0);
        step(enc_i(4, 0, 8'h00), 1'b1, "R6 r0 untouched");

        // R9: ignored words leave registers and flags alone
        step(enc_r(0, 1, 6, 0, 7), 1'b0, "R9");
        step({1'b0, 15'h7FFF}, 1'b1, "R9");
        step(enc_r(0, 1, 6, 2, 7), 1'b1, "R9");
        step(enc_r(1, 1, 6, 3, 7), 1'b1, "R9");
        step(enc_i(4, 1, 8'h00), 1'b1, "R9 r1 untouched");

        // Random back-to-back stream (R2, R3, R5, R6, R7, R8)
        for (int it = 0; it < 400; it++) begin
            load(int'(rnd() % 8), rnd());
            for (int k = 0; k < 4; k++) begin
                logic [15:0] w;
                w = rnd();
                w[15] = 1'b1;
                if (!w[11]) w[4] = 1'b0;
                step(w, 1'b1, cls(w, 1'b1));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule